// File: doc/BRIEF.md
# Debug Event Pending Status Register

This block holds three sticky flags, each one a halting-type debug event that has been raised inside the core but not yet serviced: a single-step event, a reset-catch event and an OS-unlock-catch event. Internal logic raises a flag with a one-cycle set pulse. An external debugger reads the flags through a small register bus and acknowledges an event by writing a one to its flag.

The register sits at one offset of the debug window. Whether the bus may touch it depends on three inputs: core power, a double lock and a software lock. The result is full read-write access, read-only access, or an error response. Cold reset (the asynchronous reset input) and warm reset (a synchronous pulse) act differently. On a warm reset the reset-catch flag is loaded from a control input. A parameter selects whether warm reset also loads the step flag from a control input or leaves the step flag untouched.

Top module: `dbg_evt_pend_reg`

## Requirements
- R1: While `rst_n` is low and after it rises, all three flags are 0 and `bus_ready` and `bus_err` are 0, whatever the control inputs.
- R2: Read data places the step flag at bit 2, the reset-catch flag at bit 1 and the OS-unlock-catch flag at bit 0. Bits 31 to 3 always read 0, and writing ones to them changes nothing.
- R3: A one on bit k of `evt_set` in a cycle with power on and no warm reset makes flag k read as 1 from the next cycle on.
- R4: In read-write mode, a write with bit k of the data set to 1 clears flag k. A data bit of 0 leaves its flag unchanged.
- R5: When a set pulse and a write-one clear reach the same flag in the same cycle, the flag ends up 1.
- R6: A warm reset pulse loads the reset-catch flag from `ctl_rce` and clears the OS-unlock-catch flag. With `STEP_WARM_LOAD`=1 it loads the step flag from `ctl_step`; with 0 it leaves the step flag unchanged. Warm reset takes precedence over set pulses.
- R7: While `core_pwr` is low, all flags are held at 0, and a flag that was pending is lost.
- R8: With `core_pwr`=1, `dbg_dlock`=0 and `sw_lock`=1, reads return the flags with `bus_err`=0, and writes are ignored with `bus_err`=0.
- R9: With `core_pwr`=0 or `dbg_dlock`=1, an access is answered with `bus_err`=1 and read data 0, and a write clears nothing.
- R10: Only a valid access at byte offset `REG_OFS` (default 0x020) is answered, with `bus_ready` high in the next cycle. Any other offset gets no `bus_ready` and changes no flag.
- R11: Read data shows the flags as they were in the access cycle. A set pulse in that same cycle appears only on a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, active low, asynchronous assert |
| warm_rst | input | 1 | Warm reset pulse, synchronous, active high |
| core_pwr | input | 1 | Core power is on |
| dbg_dlock | input | 1 | Double lock set |
| sw_lock | input | 1 | Software lock set |
| ctl_step | input | 1 | Step control bit, warm-reset source for the step flag |
| ctl_rce | input | 1 | Reset-catch enable, warm-reset source for the reset-catch flag |
| evt_set | input | 3 | Set pulses: [2] step, [1] reset catch, [0] OS-unlock catch |
| bus_valid | input | 1 | Access request |
| bus_addr | input | ADDR_W | Byte offset in the debug window |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Response, one cycle after an accepted request |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_err | output | 1 | Error response, valid with `bus_ready` |

## Verification
The flag assertions assume that `core_pwr`, `warm_rst` and `evt_set` are ordinary synchronous inputs. Each assertion names the precedence conditions (power off first, then warm reset, then set, then clear) in its antecedent, so that it never fires when an input of higher rank overrides the lower one. The bus assertions assume that a request is a single-cycle pulse of `bus_valid`. The bench drives every input on the falling edge and holds each request for exactly one cycle. It sweeps all combinations of preloaded flags, write masks and same-cycle set pulses, then all eight power and lock combinations, and then warm reset with every control value against a default instance and an instance in the alternate configuration.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;
  localparam int NFLAG    = 3;
  localparam int BIT_STEP = 2;
  localparam int BIT_RC   = 1;
  localparam int BIT_OSUC = 0;

  typedef enum logic [1:0] {
    ACC_ERR = 2'd0,
    ACC_RO  = 2'd1,
    ACC_RW  = 2'd2
  } acc_mode_e;
endpackage

// File: rtl/dbg_evt_access.sv
module dbg_evt_access
  import dbg_evt_pkg::*;
(
  input  logic      core_pwr,
  input  logic      dbg_dlock,
  input  logic      sw_lock,
  output acc_mode_e mode
);
  always_comb begin
    if (!core_pwr || dbg_dlock) mode = ACC_ERR;
    else if (sw_lock)           mode = ACC_RO;
    else                        mode = ACC_RW;
  end
endmodule

// File: rtl/dbg_evt_flag.sv
module dbg_evt_flag #(
  parameter bit WARM_LOAD = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic core_pwr,
  input  logic warm_rst,
  input  logic warm_val,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q, pend_d, pend_en, warm_hit;

  generate
    if (WARM_LOAD) begin : g_warm_load
      assign warm_hit = warm_rst;
    end else begin : g_warm_hold
      logic unused_warm;
      assign unused_warm = warm_rst ^ warm_val;
      assign warm_hit    = 1'b0;
    end
  endgenerate

  always_comb begin
    pend_en = !core_pwr || warm_hit || set_i || clr_i;
    if (!core_pwr)     pend_d = 1'b0;
    else if (warm_hit) pend_d = warm_val;
    else if (set_i)    pend_d = 1'b1;
    else               pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_pwr && !warm_hit && set_i) |=> pend_o);

  // R7
  pwr_off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_pwr |=> !pend_o);

  // R6
  warm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_pwr && warm_hit) |=> (pend_o == $past(warm_val)));
endmodule

// File: rtl/dbg_evt_pend_reg.sv
module dbg_evt_pend_reg
  import dbg_evt_pkg::*;
#(
  parameter int          ADDR_W         = 12,
  parameter int          REG_W          = 32,
  parameter logic [11:0] REG_OFS        = 12'h020,
  parameter bit          STEP_WARM_LOAD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              core_pwr,
  input  logic              dbg_dlock,
  input  logic              sw_lock,
  input  logic              ctl_step,
  input  logic              ctl_rce,
  input  logic [NFLAG-1:0]  evt_set,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic              bus_ready,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_err
);
  localparam int RSV_W = REG_W - NFLAG;
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);

  acc_mode_e        mode;
  logic             hit;
  logic [NFLAG-1:0] clr_vec, flags, warm_vals;
  logic             ready_d, err_d, ready_q, err_q;
  logic [REG_W-1:0] rdata_d, rdata_q;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[REG_W-1:NFLAG];

  dbg_evt_access u_access (
    .core_pwr (core_pwr),
    .dbg_dlock(dbg_dlock),
    .sw_lock  (sw_lock),
    .mode     (mode)
  );

  always_comb begin
    warm_vals           = '0;
    warm_vals[BIT_STEP] = ctl_step;
    warm_vals[BIT_RC]   = ctl_rce;
    warm_vals[BIT_OSUC] = 1'b0;
  end

  assign hit = bus_valid && (bus_addr == OFS);

  always_comb begin
    clr_vec = '0;
    if (hit && bus_write && (mode == ACC_RW)) clr_vec = bus_wdata[NFLAG-1:0];
  end

  genvar k;
  generate
    for (k = 0; k < NFLAG; k++) begin : g_flag
      dbg_evt_flag #(
        .WARM_LOAD((k == BIT_STEP) ? STEP_WARM_LOAD : 1'b1)
      ) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .core_pwr(core_pwr),
        .warm_rst(warm_rst),
        .warm_val(warm_vals[k]),
        .set_i   (evt_set[k]),
        .clr_i   (clr_vec[k]),
        .pend_o  (flags[k])
      );
    end
  endgenerate

  always_comb begin
    ready_d = hit;
    err_d   = hit && (mode == ACC_ERR);
    rdata_d = '0;
    if (hit && !bus_write && (mode != ACC_ERR)) rdata_d = {{RSV_W{1'b0}}, flags};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ready_q <= ready_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_ready = ready_q;
  assign bus_err   = err_q;
  assign bus_rdata = rdata_q;

  // R10
  decode_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> $past(bus_valid && (bus_addr == OFS)));

  // R9
  err_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && bus_err) |-> (bus_rdata == '0));

  // R8
  ro_write_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bus_write && core_pwr && !dbg_dlock && sw_lock && !warm_rst && (evt_set == '0))
      |=> (flags == $past(flags)));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bus_write && core_pwr && !dbg_dlock && !sw_lock && !warm_rst)
      |=> ((flags & $past(bus_wdata[NFLAG-1:0] & ~evt_set)) == '0));

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> (bus_rdata[REG_W-1:NFLAG] == '0));
endmodule

// File: tb/dbg_evt_pend_reg_tb.sv
module dbg_evt_pend_reg_tb;
  localparam logic [11:0] OFS = 12'h020;

  logic clk = 1'b0;
  logic rst_n, warm_rst, core_pwr, dbg_dlock, sw_lock, ctl_step, ctl_rce;
  logic [2:0]  evt_set;
  logic        bus_valid, bus_write;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        rdy, err, rdy_a, err_a;
  logic [31:0] rdata, rdata_a;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbg_evt_pend_reg u_dut (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .core_pwr(core_pwr),
    .dbg_dlock(dbg_dlock), .sw_lock(sw_lock), .ctl_step(ctl_step), .ctl_rce(ctl_rce),
    .evt_set(evt_set), .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_ready(rdy), .bus_rdata(rdata), .bus_err(err));

  dbg_evt_pend_reg #(.STEP_WARM_LOAD(1'b0)) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .core_pwr(core_pwr),
    .dbg_dlock(dbg_dlock), .sw_lock(sw_lock), .ctl_step(ctl_step), .ctl_rce(ctl_rce),
    .evt_set(evt_set), .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_ready(rdy_a), .bus_rdata(rdata_a), .bus_err(err_a));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample registered outputs at next negedge
  task automatic cyc(input logic v, input logic wr, input logic [11:0] a,
                     input logic [31:0] wd, input logic [2:0] s, input logic wm);
    bus_valid = v; bus_write = wr; bus_addr = a; bus_wdata = wd;
    evt_set = s; warm_rst = wm;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; evt_set = 0; warm_rst = 0;
  endtask

  task automatic rd();
    cyc(1, 0, OFS, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; warm_rst = 0; core_pwr = 1; dbg_dlock = 0; sw_lock = 0;
    ctl_step = 1; ctl_rce = 1; evt_set = 0; bus_valid = 0; bus_write = 0;
    bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'b0, rdy}, 0);
    chk("R1 err in reset", {31'b0, err}, 0);
    rst_n = 1;
    @(negedge clk);
    rd();
    chk("R1 cold flags", rdata, 0);
    chk("R1 cold flags alt", rdata_a, 0);
    chk("R1 err after reset", {31'b0, err}, 0);

    // R3 R4 R5 R11 sweep: preload a, then write mask w with same-cycle set s
    for (int a = 0; a < 8; a++)
      for (int w = 0; w < 8; w++)
        for (int s = 0; s < 8; s++) begin
          cyc(1, 1, OFS, 32'h7, 0, 0);
          cyc(1, 0, OFS, 0, 3'(a), 0);
          chk("R11 read before same-cycle set", rdata, 0);
          cyc(1, 1, OFS, 32'(w), 3'(s), 0);
          chk("R4 write response", {30'b0, rdy, err}, 32'h2);
          rd();
          chk("R5 R4 R3 flags after set/clear", rdata, 32'((a & ~w) | s));
          chk("R5 R4 R3 flags alt", rdata_a, 32'((a & ~w) | s));
        end

    // R2 reserved bits ignore writes
    cyc(0, 0, 0, 0, 3'h7, 0);
    cyc(1, 1, OFS, 32'hFFFF_FFF8, 0, 0);
    rd();
    chk("R2 reserved write no effect", rdata, 32'h7);
    // R2 bit layout: step on bit 2 only
    cyc(1, 1, OFS, 32'h3, 0, 0);
    rd();
    chk("R2 step at bit 2", rdata, 32'h4);

    // R10 other offsets not decoded
    cyc(1, 1, 12'h024, 32'h7, 3'h3, 0);
    chk("R10 no ready on 0x024", {31'b0, rdy}, 0);
    cyc(1, 0, 12'h000, 0, 0, 0);
    chk("R10 no ready on 0x000", {31'b0, rdy}, 0);
    rd();
    chk("R10 foreign write ignored", rdata, 32'h7);

    // R7 R8 R9 mode sweep over {pwr, dlock, slock}
    for (int m = 0; m < 8; m++) begin
      logic p, dl, sl, e;
      logic [2:0] after;
      p = m[2]; dl = m[1]; sl = m[0];
      core_pwr = 1; dbg_dlock = 0; sw_lock = 0;
      cyc(0, 0, 0, 0, 3'h7, 0);
      core_pwr = p; dbg_dlock = dl; sw_lock = sl;
      e = !p || dl;
      cyc(1, 1, OFS, 32'h7, 0, 0);
      chk("R9 R8 write ready", {31'b0, rdy}, 1);
      chk("R9 R8 write err", {31'b0, err}, {31'b0, e});
      rd();
      chk("R9 R8 read err", {31'b0, err}, {31'b0, e});
      if (!p) after = 3'h0;
      else if (!dl && !sl) after = 3'h0;
      else after = 3'h7;
      chk("R9 R8 read data", rdata, e ? 32'h0 : 32'(after));
      core_pwr = 1; dbg_dlock = 0; sw_lock = 0;
      rd();
      chk("R7 R8 R9 flags afterwards", rdata, 32'(after));
    end

    // R7 set pulses ignored while unpowered
    core_pwr = 0;
    cyc(0, 0, 0, 0, 3'h7, 0);
    core_pwr = 1;
    rd();
    chk("R7 set while unpowered lost", rdata, 0);

    // R6 warm reset with every control value and preload
    for (int c = 0; c < 4; c++)
      for (int pre = 0; pre < 8; pre++) begin
        logic [2:0] pv;
        pv = 3'(pre);
        cyc(1, 1, OFS, 32'h7, 0, 0);
        cyc(0, 0, 0, 0, pv, 0);
        ctl_step = c[1]; ctl_rce = c[0];
        cyc(0, 0, 0, 0, 3'h7, 1);
        rd();
        chk("R6 warm default", rdata, {29'b0, c[1], c[0], 1'b0});
        chk("R6 warm alt", rdata_a, {29'b0, 1'b1, c[0], 1'b0});
        cyc(1, 1, OFS, 32'h7, 0, 0);
        cyc(0, 0, 0, 0, pv, 0);
        cyc(0, 0, 0, 0, 0, 1);
        rd();
        chk("R6 warm alt keeps step", rdata_a, {29'b0, pv[2], c[0], 1'b0});
      end

    // R1 cold reset clears the alternate step flag
    cyc(0, 0, 0, 0, 3'h7, 0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd();
    chk("R1 cold clears alt", rdata_a, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule